// File: doc/BRIEF.md
# Gated Up/Down Pulse Counter

This block counts edges on a single pulse input and keeps two tallies of them. Each counted edge is first classified as an up-event or a down-event. A software direction bit decides the class, unless the external direction input has been enabled to decide it instead. The main tally moves up or down. It wraps against a programmable ceiling and raises a one-cycle flag at each wrap. The auxiliary tally only ever increments, even for down-events, and it wraps silently at all-ones.

The two tallies use separate event filters with different code tables. This lets one input stream feed two measurements at once. For example, the main tally can keep a net position while the auxiliary tally counts only the reversals in one direction. A 2-bit run mode enables counting. The two single-input modes behave identically here. The off code and the reserved code both freeze the block.

Top module: `pulse_tally`

## Requirements
- R1: After synchronous reset both tallies read 0 and both wrap flags are low.
- R2: With run mode 0 (off) or 3 (reserved), pulses leave both tallies unchanged and raise no flag. Modes 1 and 2 both enable counting.
- R3: `edge_fall` = 0 counts low-to-high transitions of `strobe_in`. `edge_fall` = 1 counts high-to-low transitions. The other transition is ignored.
- R4: With `ext_dir_en` = 0, `sw_dir` = 0 classifies an edge as an up-event and `sw_dir` = 1 as a down-event. With `ext_dir_en` = 1, `dir_in` classifies the edge the same way (1 = down) and `sw_dir` has no effect.
- R5: Main filter `main_sel`: code 0 increments on up-events and decrements on down-events. Code 1 increments on up-events only. Code 2 decrements on down-events only. Code 3 never changes the main tally.
- R6: Auxiliary filter `aux_sel`: code 0 never counts. Code 1 increments on up-events. Code 2 increments on down-events. Code 3 increments on both. The auxiliary tally never decreases.
- R7: An increment of the main tally while it equals `top_val` loads 0 and raises `wrap_up` for exactly one cycle.
- R8: A decrement of the main tally while it is 0 loads `top_val` and raises `wrap_down` for exactly one cycle.
- R9: The auxiliary tally wraps from all-ones to 0 without any flag.
- R10: A counted edge is visible on the tally outputs (and flags) right after the first clock edge that samples the new `strobe_in` level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 2 | 0 off, 1/2 single-input counting, 3 reserved (off) |
| sw_dir | input | 1 | Software direction: 0 up, 1 down |
| ext_dir_en | input | 1 | 1 lets `dir_in` choose direction |
| edge_fall | input | 1 | 0 count rising edges, 1 count falling edges |
| main_sel | input | 2 | Main tally event filter code |
| aux_sel | input | 2 | Auxiliary tally event filter code |
| top_val | input | CNT_W | Main tally ceiling |
| strobe_in | input | 1 | Synchronised pulse input |
| dir_in | input | 1 | Synchronised direction input: 0 up, 1 down |
| main_count | output | CNT_W | Main tally |
| aux_count | output | AUX_W | Auxiliary tally |
| wrap_up | output | 1 | One-cycle flag: main tally wrapped from ceiling to 0 |
| wrap_down | output | 1 | One-cycle flag: main tally wrapped from 0 to ceiling |

## Verification
The only internal state is the previous strobe level and the two tallies. A stale previous level shows up as a count on the wrong transition, or as a double count, one cycle after the strobe moves. A misclassified event or a wrong filter decode shows up as a tally that moves by the wrong step, or not at all, on the very next clock. A wrong wrap boundary shows up as a missing or misplaced flag, and as a count other than 0 or the ceiling, on the same edge that wraps. Directed sequences hit each code of both filters, both edges and both direction sources, and sample one cycle after each transition.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;

    typedef enum logic [1:0] {
        RUN_OFF      = 2'd0,
        RUN_SINGLE_A = 2'd1,
        RUN_SINGLE_B = 2'd2,
        RUN_RESERVED = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        MSEL_BOTH = 2'd0,
        MSEL_UP   = 2'd1,
        MSEL_DOWN = 2'd2,
        MSEL_HOLD = 2'd3
    } main_sel_e;

    typedef enum logic [1:0] {
        ASEL_NONE = 2'd0,
        ASEL_UP   = 2'd1,
        ASEL_DOWN = 2'd2,
        ASEL_ANY  = 2'd3
    } aux_sel_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    // Classified edge: at most one of the two bits is set.
    typedef struct packed {
        logic up;
        logic down;
    } pulse_evt_t;

    function automatic logic mode_runs(input run_mode_e m);
        return (m == RUN_SINGLE_A) || (m == RUN_SINGLE_B);
    endfunction

    function automatic step_e main_step(input main_sel_e sel, input pulse_evt_t ev);
        step_e s;
        s = STEP_NONE;
        unique case (sel)
            MSEL_BOTH: begin
                if (ev.up)        s = STEP_INC;
                else if (ev.down) s = STEP_DEC;
            end
            MSEL_UP:   if (ev.up)   s = STEP_INC;
            MSEL_DOWN: if (ev.down) s = STEP_DEC;
            default:   s = STEP_NONE;
        endcase
        return s;
    endfunction

    function automatic logic aux_hit(input aux_sel_e sel, input pulse_evt_t ev);
        logic h;
        unique case (sel)
            ASEL_UP:   h = ev.up;
            ASEL_DOWN: h = ev.down;
            ASEL_ANY:  h = ev.up | ev.down;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pt_event_gen.sv
module pt_event_gen
    import pulse_tally_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       strobe_in,
    input  logic       dir_in,
    input  logic       sw_dir,
    input  logic       ext_dir_en,
    input  logic       edge_fall,
    output pulse_evt_t evt
);
    logic prev_q;
    logic rise, fall, hit, go_down;

    // The previous level tracks in every mode, so a mode change never fakes an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= strobe_in;
    end

    always_comb begin
        rise    = strobe_in & ~prev_q;
        fall    = ~strobe_in & prev_q;
        hit     = active & (edge_fall ? fall : rise);
        go_down = ext_dir_en ? dir_in : sw_dir;
        evt.up   = hit & ~go_down;
        evt.down = hit & go_down;
    end
endmodule

// File: rtl/pt_main_ctr.sv
module pt_main_ctr
    import pulse_tally_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap_up,
    output logic             wrap_down
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= ZERO;
            wrap_up   <= 1'b0;
            wrap_down <= 1'b0;
        end else begin
            wrap_up   <= 1'b0;
            wrap_down <= 1'b0;
            unique case (step)
                STEP_INC: begin
                    if (count == top_val) begin
                        count   <= ZERO;
                        wrap_up <= 1'b1;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
                STEP_DEC: begin
                    if (count == ZERO) begin
                        count     <= top_val;
                        wrap_down <= 1'b1;
                    end else begin
                        count <= count - 1'b1;
                    end
                end
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pt_aux_ctr.sv
module pt_aux_ctr #(
    parameter int AUX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [AUX_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (hit) count <= count + 1'b1;
    end
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
    import pulse_tally_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AUX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       run_mode,
    input  logic             sw_dir,
    input  logic             ext_dir_en,
    input  logic             edge_fall,
    input  logic [1:0]       main_sel,
    input  logic [1:0]       aux_sel,
    input  logic [CNT_W-1:0] top_val,
    input  logic             strobe_in,
    input  logic             dir_in,
    output logic [CNT_W-1:0] main_count,
    output logic [AUX_W-1:0] aux_count,
    output logic             wrap_up,
    output logic             wrap_down
);
    logic       active;
    pulse_evt_t evt;
    step_e      m_step;
    logic       a_hit;

    assign active = mode_runs(run_mode_e'(run_mode));
    assign m_step = main_step(main_sel_e'(main_sel), evt);
    assign a_hit  = aux_hit(aux_sel_e'(aux_sel), evt);

    pt_event_gen u_evt (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .strobe_in  (strobe_in),
        .dir_in     (dir_in),
        .sw_dir     (sw_dir),
        .ext_dir_en (ext_dir_en),
        .edge_fall  (edge_fall),
        .evt        (evt)
    );

    pt_main_ctr #(.CNT_W(CNT_W)) u_main (
        .clk       (clk),
        .rst       (rst),
        .step      (m_step),
        .top_val   (top_val),
        .count     (main_count),
        .wrap_up   (wrap_up),
        .wrap_down (wrap_down)
    );

    pt_aux_ctr #(.AUX_W(AUX_W)) u_aux (
        .clk   (clk),
        .rst   (rst),
        .hit   (a_hit),
        .count (aux_count)
    );
endmodule

// File: rtl/pulse_tally_chk.sv
module pulse_tally_chk #(
    parameter int CNT_W = 16,
    parameter int AUX_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       run_mode,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] main_count,
    input logic [AUX_W-1:0] aux_count,
    input logic             wrap_up,
    input logic             wrap_down
);
    logic frozen;
    assign frozen = (run_mode == 2'd0) || (run_mode == 2'd3);

    p_hold_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(main_count) && $stable(aux_count)));

    p_no_flag_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (!wrap_up && !wrap_down));

    p_aux_monotone_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (aux_count == $past(aux_count) ||
                  aux_count == AUX_W'($past(aux_count) + 1'b1)));

    p_wrap_lands_zero_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_up |-> (main_count == '0));

    p_wrap_single_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_up |=> !wrap_up);

    p_under_lands_top_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap_down) |-> (main_count == $past(top_val)));

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(wrap_up && wrap_down));
endmodule

bind pulse_tally pulse_tally_chk #(.CNT_W(CNT_W), .AUX_W(AUX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_mode   (run_mode),
    .top_val    (top_val),
    .main_count (main_count),
    .aux_count  (aux_count),
    .wrap_up    (wrap_up),
    .wrap_down  (wrap_down)
);

// File: tb/pulse_tally_test.sv
`timescale 1ns/1ps
module pulse_tally_test;
    localparam int CNT_W = 8;
    localparam int AUX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       run_mode = 2'd0;
    logic             sw_dir = 1'b0;
    logic             ext_dir_en = 1'b0;
    logic             edge_fall = 1'b0;
    logic [1:0]       main_sel = 2'd0;
    logic [1:0]       aux_sel = 2'd0;
    logic [CNT_W-1:0] top_val = 8'd200;
    logic             strobe_in = 1'b0;
    logic             dir_in = 1'b0;
    logic [CNT_W-1:0] main_count;
    logic [AUX_W-1:0] aux_count;
    logic             wrap_up, wrap_down;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    int  fw1, fu1, fw2, fu2;

    always #2 clk = ~clk;

    pulse_tally #(.CNT_W(CNT_W), .AUX_W(AUX_W)) uut (
        .clk(clk), .rst(rst), .run_mode(run_mode), .sw_dir(sw_dir),
        .ext_dir_en(ext_dir_en), .edge_fall(edge_fall), .main_sel(main_sel),
        .aux_sel(aux_sel), .top_val(top_val), .strobe_in(strobe_in),
        .dir_in(dir_in), .main_count(main_count), .aux_count(aux_count),
        .wrap_up(wrap_up), .wrap_down(wrap_down)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        strobe_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a negedge with strobe low; returns at a negedge with strobe low.
    task automatic pulse();
        strobe_in = 1'b1;
        @(negedge clk);
        fw1 = wrap_up; fu1 = wrap_down;
        strobe_in = 1'b0;
        @(negedge clk);
        fw2 = wrap_up; fu2 = wrap_down;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 main after reset", main_count, 0);
        chk("R1 aux after reset", aux_count, 0);
        chk("R1 flags after reset", wrap_up + wrap_down, 0);
    endtask

    task automatic t_frozen();
        do_reset();
        main_sel = 2'd0; aux_sel = 2'd3; sw_dir = 1'b0; top_val = 8'd200;
        run_mode = 2'd0;
        pulse(); pulse();
        chk("R2 mode0 main", main_count, 0);
        chk("R2 mode0 aux", aux_count, 0);
        chk("R2 mode0 flags", fw1 + fu1 + fw2 + fu2, 0);
        run_mode = 2'd3;
        sw_dir = 1'b1;
        pulse();
        chk("R2 mode3 main", main_count, 0);
        chk("R2 mode3 flags", fw1 + fu1, 0);
        chk("R2 mode3 aux", aux_count, 0);
    endtask

    task automatic t_edges();
        do_reset();
        run_mode = 2'd1; main_sel = 2'd0; aux_sel = 2'd0; sw_dir = 1'b0;
        ext_dir_en = 1'b0; edge_fall = 1'b0; top_val = 8'd200;
        strobe_in = 1'b1;
        @(negedge clk);
        chk("R10 rising counted after one edge", main_count, 1);
        strobe_in = 1'b0;
        @(negedge clk);
        chk("R3 falling ignored in rising mode", main_count, 1);
        edge_fall = 1'b1;
        strobe_in = 1'b1;
        @(negedge clk);
        chk("R3 rising ignored in falling mode", main_count, 1);
        strobe_in = 1'b0;
        @(negedge clk);
        chk("R3 falling counted", main_count, 2);
        edge_fall = 1'b0;
    endtask

    task automatic t_dir();
        // continues from main_count = 2
        sw_dir = 1'b1;
        pulse();
        chk("R4 sw down", main_count, 1);
        ext_dir_en = 1'b1; sw_dir = 1'b0; dir_in = 1'b1;
        pulse();
        chk("R4 ext down overrides sw", main_count, 0);
        dir_in = 1'b0; sw_dir = 1'b1;
        pulse();
        chk("R4 ext up overrides sw", main_count, 1);
        ext_dir_en = 1'b0;
    endtask

    task automatic t_main_sel();
        // continues from main_count = 1
        main_sel = 2'd1;
        sw_dir = 1'b1; pulse();
        chk("R5 code1 down ignored", main_count, 1);
        sw_dir = 1'b0; pulse();
        chk("R5 code1 up counts", main_count, 2);
        main_sel = 2'd2;
        sw_dir = 1'b0; pulse();
        chk("R5 code2 up ignored", main_count, 2);
        sw_dir = 1'b1; pulse();
        chk("R5 code2 down counts", main_count, 1);
        main_sel = 2'd3;
        sw_dir = 1'b0; pulse();
        sw_dir = 1'b1; pulse();
        chk("R5 code3 holds", main_count, 1);
        chk("R6 code0 aux never counted", aux_count, 0);
    endtask

    task automatic t_aux();
        do_reset();
        run_mode = 2'd1; main_sel = 2'd3; top_val = 8'd200; edge_fall = 1'b0;
        aux_sel = 2'd1;
        sw_dir = 1'b0; pulse();
        chk("R6 code1 up", aux_count, 1);
        sw_dir = 1'b1; pulse();
        chk("R6 code1 down ignored", aux_count, 1);
        aux_sel = 2'd2;
        sw_dir = 1'b1; pulse();
        chk("R6 code2 down increments", aux_count, 2);
        sw_dir = 1'b0; pulse();
        chk("R6 code2 up ignored", aux_count, 2);
        aux_sel = 2'd3;
        sw_dir = 1'b0; pulse();
        sw_dir = 1'b1; pulse();
        chk("R6 code3 both increment", aux_count, 4);
        chk("R5 code3 main untouched", main_count, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        run_mode = 2'd1; main_sel = 2'd0; aux_sel = 2'd0; sw_dir = 1'b0;
        top_val = 8'd3;
        for (int i = 0; i < 3; i++) pulse();
        chk("R7 at top", main_count, 3);
        chk("R7 no flag below top", fw1, 0);
        pulse();
        chk("R7 wrap flag raised", fw1, 1);
        chk("R7 no under flag", fu1, 0);
        chk("R7 flag one cycle", fw2, 0);
        chk("R7 wrapped to zero", main_count, 0);
    endtask

    task automatic t_under();
        do_reset();
        run_mode = 2'd2; main_sel = 2'd0; aux_sel = 2'd0; sw_dir = 1'b1;
        top_val = 8'd3;
        pulse();
        chk("R8 under flag raised", fu1, 1);
        chk("R8 flag one cycle", fu2, 0);
        chk("R8 reloaded to top", main_count, 3);
        pulse();
        chk("R8 plain decrement no flag", fu1, 0);
        chk("R8 decrement value", main_count, 2);
    endtask

    task automatic t_aux_wrap();
        do_reset();
        run_mode = 2'd1; main_sel = 2'd3; aux_sel = 2'd3; sw_dir = 1'b0;
        top_val = 8'd200;
        for (int i = 0; i < 15; i++) pulse();
        chk("R9 aux at all-ones", aux_count, 15);
        pulse();
        chk("R9 aux wrapped to zero", aux_count, 0);
        chk("R9 no flag on aux wrap", fw1 + fu1 + fw2 + fu2, 0);
    endtask

    initial begin
        t_reset();
        t_frozen();
        t_edges();
        t_dir();
        t_main_sel();
        t_aux();
        t_wrap();
        t_under();
        t_aux_wrap();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule